// File: doc/BRIEF.md
# Indirect Register Access Port for a Dual-Channel Serial Controller

This block is the bus-facing register front end of a two-channel serial controller. The bus sees only two byte locations: a control location and a data location. Sixteen write registers and sixteen read registers sit behind the control location and are reached through a one-shot pointer. A control write while the pointer is zero goes to register 0. Its low three bits name the next register and its bits 5:3 carry a command. The next control access, read or write, reaches the named register, and the pointer then falls back to zero.

The block holds the write-register storage and drives it out to the serial engines. Read-register values come in on status inputs. The data location always reaches the transmit buffer on writes and the receive buffer on reads, and it leaves the pointer alone. A few writes act as controls rather than as stored values:
- a command that points into the upper half of the registers;
- an error-clear command;
- channel-reset bits in register 9;
- a shadow register at index 7 that switches control reads over to write-register readback.

Top module: `serial_regport`

## Requirements
- R1: A hardware reset clears the pointer, all write registers (including the shadow register) and all pulse outputs to 0. A control read issued after reset returns status register 0.
- R2: A control read while the pointer is 0 returns status register 0. A control write while the pointer is 0 pulses `cmd_stb_o` for one cycle in the following cycle, with `cmd_o` equal to bits 5:3 of the written byte.
- R3: A control write of value n (n in 1..7, bits 5:3 zero) at pointer 0 makes the next control write store into write register n, and the next control read return status register n.
- R4: Command code 3'b001 in bits 5:3 of a register-0 write sets the pointer to 8 plus bits 2:0. The value 0x08 therefore selects register 8 and the value 0x0A selects register 10.
- R5: After any control access made while the pointer is nonzero, the pointer returns to 0.
- R6: A data-location write stores into write register 8 and pulses `tx_load_o`. A data-location read returns `rx_data_i` and pulses `rx_pop_o`. A control access to register 8 does the same. Data-location accesses leave the pointer unchanged.
- R7: Command code 3'b110 (register-0 value 0x30) pulses `err_clr_o` for one cycle. Other codes do not pulse it.
- R8: A write to register 9 with bit 7 set pulses `ch_a_rst_o` and with bit 6 set pulses `ch_b_rst_o`. With both bits set (0xC0), all write registers and the shadow register are also cleared. Bits 7:6 are never stored, so slot 9 keeps only bits 5:0.
- R9: While bit 0 of write register 15 is 1, writes to register 7 go to the shadow register (`alt7_o`) and write register 7 keeps its value.
- R10: While bit 6 of the shadow register is 1, control reads of registers 1..7 and 9..15 return the write register with the same number. Register 0 always returns status, and register 8 always returns `rx_data_i`.
- R11: A cycle with `bus_sel` low changes no register and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dsel | input | 1 | 1 = data location, 0 = control location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rd_stat_i | input | 128 | Status registers, slot k at bits 8k+7:8k |
| rx_data_i | input | 8 | Receive buffer contents |
| wr_regs_o | output | 128 | Write registers, slot k at bits 8k+7:8k, slot 0 always 0 |
| alt7_o | output | 8 | Shadow register behind index 7 |
| tx_load_o | output | 1 | Pulse: transmit buffer written |
| rx_pop_o | output | 1 | Pulse: receive buffer read |
| err_clr_o | output | 1 | Pulse: error-clear command |
| cmd_stb_o | output | 1 | Pulse: register-0 write seen |
| cmd_o | output | 3 | Command code of the last register-0 write |
| ch_a_rst_o | output | 1 | Pulse: channel A reset |
| ch_b_rst_o | output | 1 | Pulse: channel B reset |

## Verification
The bench targets the pointer's one-shot behaviour:
- A pointer that fails to fall back to zero would send a second control read to a stale register instead of status 0.
- A point-high command that ignores bit 3 would read status 2 instead of status 10.

It places a data access between pointer-setting steps, because a design that let the data path touch the pointer would send the following control access to the wrong register. It also covers three register-specific cases:
- the shadow redirect, where a wrong design would overwrite write register 7;
- readback, where register 0 must still return status;
- the full reset through register 9, where a design that stored bits 7:6 or cleared only one channel's state would leave nonzero slots behind.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int SRP_DW    = 8;
  localparam int SRP_NREG  = 16;
  localparam int SRP_LOW_W = 3;   // register-0 select field width

  localparam int IDX_ALT = 7;     // shadow register sits behind this index
  localparam int IDX_TX  = 8;     // transmit / receive buffer index
  localparam int IDX_MIC = 9;     // master control: channel resets
  localparam int IDX_EXT = 15;    // bit 0 redirects writes to the shadow

  localparam int ALT_RB_BIT = 6;  // shadow bit enabling readback
  localparam int EXT_EN_BIT = 0;

  typedef enum logic [2:0] {
    CMD_NULL   = 3'd0,
    CMD_HIGH   = 3'd1,
    CMD_EXTRST = 3'd2,
    CMD_ABORT  = 3'd3,
    CMD_RXFC   = 3'd4,
    CMD_TXP    = 3'd5,
    CMD_ERRCLR = 3'd6,
    CMD_IUS    = 3'd7
  } srp_cmd_e;
endpackage

// File: rtl/srp_ptr.sv
module srp_ptr
  import srp_pkg::*;
#(
  parameter int NREG = SRP_NREG,
  localparam int PW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_acc,
  input  logic                   ctl_wr,
  input  logic                   dat_acc,
  input  logic [SRP_LOW_W+2:0]   wsel,
  output logic [PW-1:0]          ptr_o
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  srp_cmd_e      cmd;

  assign cmd    = srp_cmd_e'(wsel[SRP_LOW_W+2:SRP_LOW_W]);
  assign ptr_en = ctl_acc;

  always_comb begin
    ptr_d = '0;
    if (ptr_q == '0 && ctl_wr) begin
      ptr_d = PW'(wsel[SRP_LOW_W-1:0]);
      if (cmd == CMD_HIGH) ptr_d = ptr_d | PW'(NREG/2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R5: a control access at a nonzero pointer always returns it to zero
  a_r5_ptr_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && ptr_q != '0) |=> (ptr_q == '0));

  // R6: data-location accesses never move the pointer
  a_r6_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !ctl_acc) |=> $stable(ptr_q));

  // R11: idle cycles keep the pointer
  a_r11_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_acc && !dat_acc) |=> $stable(ptr_q));
endmodule

// File: rtl/srp_wbank.sv
module srp_wbank
  import srp_pkg::*;
#(
  parameter int DW   = SRP_DW,
  parameter int NREG = SRP_NREG,
  localparam int PW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [PW-1:0]        idx,
  input  logic                 dat_we,
  input  logic [DW-1:0]        wdata,
  output logic [NREG*DW-1:0]   regs_o,
  output logic [DW-1:0]        alt_o,
  output logic                 tx_load_o,
  output logic                 ch_a_rst_o,
  output logic                 ch_b_rst_o
);
  logic [DW-1:0] wr_q [NREG];
  logic [DW-1:0] wr_d [NREG];
  logic [DW-1:0] alt_q, alt_d;
  logic          hit_mic, frc, to_alt, upd;
  logic          tx_d, cha_d, chb_d;

  assign hit_mic = ctl_we && (idx == PW'(IDX_MIC));
  assign frc     = hit_mic && wdata[DW-1] && wdata[DW-2];
  assign to_alt  = ctl_we && (idx == PW'(IDX_ALT)) && wr_q[IDX_EXT][EXT_EN_BIT];
  assign upd     = ctl_we || dat_we;

  assign tx_d  = dat_we || (ctl_we && idx == PW'(IDX_TX));
  assign cha_d = hit_mic && wdata[DW-1];
  assign chb_d = hit_mic && wdata[DW-2];

  always_comb begin
    wr_d  = wr_q;
    alt_d = alt_q;
    if (frc) begin
      for (int i = 0; i < NREG; i++) wr_d[i] = '0;
      alt_d = '0;
    end else begin
      if (ctl_we) begin
        if (to_alt)                      alt_d        = wdata;
        else if (idx == PW'(IDX_MIC))    wr_d[IDX_MIC] = {2'b00, wdata[DW-3:0]};
        else                             wr_d[idx]    = wdata;
      end
      if (dat_we) wr_d[IDX_TX] = wdata;
    end
    wr_d[0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= '0;
      alt_q      <= '0;
      tx_load_o  <= 1'b0;
      ch_a_rst_o <= 1'b0;
      ch_b_rst_o <= 1'b0;
    end else begin
      if (upd) begin
        wr_q  <= wr_d;
        alt_q <= alt_d;
      end
      tx_load_o  <= tx_d;
      ch_a_rst_o <= cha_d;
      ch_b_rst_o <= chb_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*DW +: DW] = wr_q[g];
  end
  assign alt_o = alt_q;

  // R8: full reset through register 9 leaves every slot and the shadow at zero
  a_r8_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> (regs_o == '0 && alt_o == '0));

  // R9: a redirected write leaves register 7 itself untouched
  a_r9_shadow_keeps_wr7: assert property (@(posedge clk) disable iff (!rst_n)
    to_alt |=> $stable(wr_q[IDX_ALT]));

  // R11: no write strobe, no change
  a_r11_idle_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(regs_o) && $stable(alt_o)));
endmodule

// File: rtl/srp_rmux.sv
module srp_rmux
  import srp_pkg::*;
#(
  parameter int DW   = SRP_DW,
  parameter int NREG = SRP_NREG,
  localparam int PW  = $clog2(NREG)
) (
  input  logic [PW-1:0]       ptr,
  input  logic                dsel,
  input  logic                rb_en,
  input  logic [NREG*DW-1:0]  stat_i,
  input  logic [NREG*DW-1:0]  wregs_i,
  input  logic [DW-1:0]       rx_i,
  output logic [DW-1:0]       rdata_o
);
  always_comb begin
    if (dsel || ptr == PW'(IDX_TX))  rdata_o = rx_i;
    else if (rb_en && ptr != '0)     rdata_o = wregs_i[int'(ptr)*DW +: DW];
    else                             rdata_o = stat_i[int'(ptr)*DW +: DW];
  end

  // R10: register 0 on the control location is status, readback or not
  always_comb begin
    if (!dsel && ptr == '0)
      a_r10_reg0_is_status: assert (rdata_o == stat_i[DW-1:0]);
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import srp_pkg::*;
#(
  parameter int DW   = SRP_DW,
  parameter int NREG = SRP_NREG,
  localparam int PW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_dsel,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NREG*DW-1:0]  rd_stat_i,
  input  logic [DW-1:0]       rx_data_i,
  output logic [NREG*DW-1:0]  wr_regs_o,
  output logic [DW-1:0]       alt7_o,
  output logic                tx_load_o,
  output logic                rx_pop_o,
  output logic                err_clr_o,
  output logic                cmd_stb_o,
  output logic [2:0]          cmd_o,
  output logic                ch_a_rst_o,
  output logic                ch_b_rst_o
);
  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic [PW-1:0] ptr;
  logic          ctl_acc, dat_acc, ctl_wr0, ctl_we, dat_we;
  logic          pop_d, err_d, stb_d, cmd_en;
  logic [2:0]    cmd_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign ctl_acc = bus_sel && !bus_dsel;
  assign dat_acc = bus_sel && bus_dsel;
  assign ctl_wr0 = ctl_acc && bus_wr && (ptr == '0);
  assign ctl_we  = ctl_acc && bus_wr && (ptr != '0);
  assign dat_we  = dat_acc && bus_wr;

  srp_ptr #(.NREG(NREG)) u_ptr (
    .clk     (clk),
    .rst_n   (srst_n),
    .ctl_acc (ctl_acc),
    .ctl_wr  (bus_wr),
    .dat_acc (dat_acc),
    .wsel    (bus_wdata[SRP_LOW_W+2:0]),
    .ptr_o   (ptr)
  );

  srp_wbank #(.DW(DW), .NREG(NREG)) u_wbank (
    .clk        (clk),
    .rst_n      (srst_n),
    .ctl_we     (ctl_we),
    .idx        (ptr),
    .dat_we     (dat_we),
    .wdata      (bus_wdata),
    .regs_o     (wr_regs_o),
    .alt_o      (alt7_o),
    .tx_load_o  (tx_load_o),
    .ch_a_rst_o (ch_a_rst_o),
    .ch_b_rst_o (ch_b_rst_o)
  );

  srp_rmux #(.DW(DW), .NREG(NREG)) u_rmux (
    .ptr     (ptr),
    .dsel    (bus_dsel),
    .rb_en   (alt7_o[ALT_RB_BIT]),
    .stat_i  (rd_stat_i),
    .wregs_i (wr_regs_o),
    .rx_i    (rx_data_i),
    .rdata_o (bus_rdata)
  );

  // command and receive-side pulses: next state
  always_comb begin
    pop_d  = bus_sel && !bus_wr && (bus_dsel || ptr == PW'(IDX_TX));
    stb_d  = ctl_wr0;
    cmd_en = ctl_wr0;
    cmd_d  = bus_wdata[SRP_LOW_W+2:SRP_LOW_W];
    err_d  = ctl_wr0 && (srp_cmd_e'(cmd_d) == CMD_ERRCLR);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rx_pop_o  <= 1'b0;
      err_clr_o <= 1'b0;
      cmd_stb_o <= 1'b0;
      cmd_o     <= '0;
    end else begin
      rx_pop_o  <= pop_d;
      err_clr_o <= err_d;
      cmd_stb_o <= stb_d;
      if (cmd_en) cmd_o <= cmd_d;
    end
  end

  // R7: error-clear pulse follows only an error-clear command
  a_r7_errclr_follows_cmd: assert property (@(posedge clk) disable iff (!srst_n)
    err_clr_o |-> (cmd_stb_o && cmd_o == 3'd6));

  // R2: a register-0 write produces a strobe on the next cycle
  a_r2_cmd_strobe: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_acc && bus_wr && ptr == '0) |=> cmd_stb_o);
endmodule

// File: tb/serial_regport_tb_top.sv
module serial_regport_tb_top;
  localparam int DW = 8;
  localparam int NREG = 16;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_dsel = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NREG*DW-1:0] rd_stat_i;
  logic [DW-1:0] rx_data_i = 8'h5C;
  logic [NREG*DW-1:0] wr_regs_o;
  logic [DW-1:0] alt7_o;
  logic tx_load_o, rx_pop_o, err_clr_o, cmd_stb_o, ch_a_rst_o, ch_b_rst_o;
  logic [2:0] cmd_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NREG; g++) begin : g_stat
    assign rd_stat_i[g*DW +: DW] = 8'hA0 + 8'(g);
  end

  serial_regport dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_dsel(bus_dsel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_stat_i(rd_stat_i), .rx_data_i(rx_data_i), .wr_regs_o(wr_regs_o),
    .alt7_o(alt7_o), .tx_load_o(tx_load_o), .rx_pop_o(rx_pop_o),
    .err_clr_o(err_clr_o), .cmd_stb_o(cmd_stb_o), .cmd_o(cmd_o),
    .ch_a_rst_o(ch_a_rst_o), .ch_b_rst_o(ch_b_rst_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one bus access; rd captured in the access cycle, pulses one cycle later
  // pl = {tx_load, rx_pop, err_clr, cmd_stb, ch_a_rst, ch_b_rst}
  task automatic acc(input logic ds, input logic w, input logic [7:0] wd,
                     output logic [7:0] rd, output logic [5:0] pl);
    @(negedge clk);
    bus_sel = 1'b1; bus_dsel = ds; bus_wr = w; bus_wdata = wd;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_dsel = 1'b0;
    pl = {tx_load_o, rx_pop_o, err_clr_o, cmd_stb_o, ch_a_rst_o, ch_b_rst_o};
  endtask

  function automatic logic [7:0] slot(input int k);
    return wr_regs_o[k*DW +: DW];
  endfunction

  // {dsel, wr, wdata, exp_rd, check, req}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'hA0, 1'b1, 4'd2},  // R2 read reg 0 directly
    {1'b0, 1'b1, 8'h03, 8'h00, 1'b0, 4'd3},  // R3 point at 3
    {1'b0, 1'b1, 8'h77, 8'h00, 1'b0, 4'd3},  // R3 store wr3
    {1'b0, 1'b0, 8'h00, 8'hA0, 1'b1, 4'd5},  // R5 back at 0
    {1'b0, 1'b1, 8'h05, 8'h00, 1'b0, 4'd3},  // R3 point at 5
    {1'b1, 1'b0, 8'h00, 8'h5C, 1'b1, 4'd6},  // R6 data read in between
    {1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 4'd6},  // R6 pointer survived data access
    {1'b0, 1'b0, 8'h00, 8'hA0, 1'b1, 4'd5},  // R5
    {1'b0, 1'b1, 8'h0A, 8'h00, 1'b0, 4'd4},  // R4 point-high + 2
    {1'b0, 1'b0, 8'h00, 8'hAA, 1'b1, 4'd4},  // R4 reads status 10
    {1'b0, 1'b1, 8'h0F, 8'h00, 1'b0, 4'd4},  // R4 point at 15
    {1'b0, 1'b1, 8'h01, 8'h00, 1'b0, 4'd9},  // R9 enable shadow redirect
    {1'b0, 1'b1, 8'h07, 8'h00, 1'b0, 4'd9},  // R9 point at 7
    {1'b0, 1'b1, 8'h40, 8'h00, 1'b0, 4'd9},  // R9 goes to shadow
    {1'b0, 1'b1, 8'h03, 8'h00, 1'b0, 4'd10}, // R10 point at 3
    {1'b0, 1'b0, 8'h00, 8'h77, 1'b1, 4'd10}, // R10 readback of wr3
    {1'b0, 1'b0, 8'h00, 8'hA0, 1'b1, 4'd10}, // R10 reg 0 still status
    {1'b0, 1'b1, 8'h08, 8'h00, 1'b0, 4'd6},  // R6 point at 8
    {1'b0, 1'b0, 8'h00, 8'h5C, 1'b1, 4'd6},  // R6 control read of rx buffer
    {1'b1, 1'b1, 8'h99, 8'h00, 1'b0, 4'd6},  // R6 data write to tx buffer
    {1'b0, 1'b1, 8'h0F, 8'h00, 1'b0, 4'd10}, // R10 point at 15
    {1'b0, 1'b0, 8'h00, 8'h01, 1'b1, 4'd10}  // R10 readback of wr15
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [5:0] pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 regs", wr_regs_o, '0);
    chk("R1 shadow", alt7_o, 8'h00);
    chk("R1 pulses", {tx_load_o, rx_pop_o, err_clr_o, cmd_stb_o, ch_a_rst_o, ch_b_rst_o}, 6'b0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][22], VEC[i][21], VEC[i][20:13], rd, pl);
      if (VEC[i][4]) chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][12:5]);
    end

    chk("R3 wr3 stored", slot(3), 8'h77);
    chk("R9 wr7 untouched", slot(7), 8'h00);
    chk("R9 shadow", alt7_o, 8'h40);
    chk("R6 wr8 from data", slot(8), 8'h99);
    chk("R4 wr15", slot(15), 8'h01);

    // R6 pulses
    acc(1'b1, 1'b1, 8'h12, rd, pl);
    chk("R6 tx_load", pl, 6'b100000);
    acc(1'b1, 1'b0, 8'h00, rd, pl);
    chk("R6 rx_pop", pl, 6'b010000);

    // R7 error clear and R2 strobe
    acc(1'b0, 1'b1, 8'h30, rd, pl);
    chk("R7 err_clr", pl, 6'b001100);
    chk("R7 cmd code", cmd_o, 3'd6);
    acc(1'b0, 1'b1, 8'h00, rd, pl);
    chk("R2 null strobe", pl, 6'b000100);
    chk("R2 cmd code", cmd_o, 3'd0);

    // R8 channel resets
    acc(1'b0, 1'b1, 8'h09, rd, pl);
    acc(1'b0, 1'b1, 8'h80, rd, pl);
    chk("R8 ch A only", pl, 6'b000010);
    chk("R8 slot9 bits7:6 dropped", slot(9), 8'h00);
    acc(1'b0, 1'b1, 8'h09, rd, pl);
    acc(1'b0, 1'b1, 8'h45, rd, pl);
    chk("R8 ch B only", pl, 6'b000001);
    chk("R8 slot9 keeps 5:0", slot(9), 8'h05);

    // R11 idle bus does nothing
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h03;
    repeat (3) @(negedge clk);
    bus_wr = 1'b0;
    chk("R11 regs unchanged", slot(3), 8'h77);
    acc(1'b0, 1'b0, 8'h00, rd, pl);
    chk("R11 pointer still 0", rd, 8'hA0);

    // R8 full reset
    acc(1'b0, 1'b1, 8'h09, rd, pl);
    acc(1'b0, 1'b1, 8'hC0, rd, pl);
    chk("R8 both channels", pl, 6'b000011);
    chk("R8 regs cleared", wr_regs_o, '0);
    chk("R8 shadow cleared", alt7_o, 8'h00);
    acc(1'b0, 1'b1, 8'h03, rd, pl);
    acc(1'b0, 1'b0, 8'h00, rd, pl);
    chk("R10 readback off after clear", rd, 8'hA3);

    // R1 hardware reset mid-run
    acc(1'b0, 1'b1, 8'h02, rd, pl);
    acc(1'b0, 1'b1, 8'h6B, rd, pl);
    acc(1'b0, 1'b1, 8'h04, rd, pl);   // leave pointer at 4
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", wr_regs_o, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc(1'b0, 1'b0, 8'h00, rd, pl);
    chk("R1 pointer cleared", rd, 8'hA0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule